// File: doc/BRIEF.md
# Power-On and Warm Reset Sequencer

This block drives chip-level reset from two active-low inputs: a power-on reset and a warm reset. From them it produces the reset for the general internal logic, a reset for the second PLL, and a reset for the test and emulation logic. It also produces a one-cycle strobe that captures the configuration pins and an active-low reset status output. All timing is counted in cycles of the reference clock `clk`.

The power-on reset asserts asynchronously and releases through a synchronizer. A warm reset is synchronized first. It counts only once it has stayed low for a minimum number of cycles, and shorter dips are discarded. After the general reset releases, the block stays in an initialization phase until `init_done` is seen, and only then does it raise the status output. During a warm reset, a peripheral pin group keeps its last functional values if that peripheral was enabled beforehand. Otherwise the group is driven to its reset value of zero.

Top module: `reset_sequencer`

## Requirements
- R1: `core_rst_n` is high only when both reset inputs are high. After the later of the two inputs rises, `core_rst_n` rises on the third rising clock edge (two synchronizer stages, then the sequencer register).
- R2: `pll2_rst_n` and `test_rst_n` depend on `por_n` alone. Both rise on the second rising edge after `por_n` rises, and the state of `warm_n` has no effect on them.
- R3: A warm reset takes effect only if `warm_n` is low for at least 24 consecutive sampling edges (`WARM_MIN_CYCLES`). A low of exactly 24 edges starts a reset sequence. A low of 23 edges leaves `core_rst_n` and `rstat_n` high throughout.
- R4: While `por_n` is low, `core_rst_n`, `pll2_rst_n`, `test_rst_n`, `rstat_n`, `cfg_latch`, `periph_pins_o` and `last_reset_warm` are all 0, and they take these values without waiting for a clock edge.
- R5: `rstat_n` is low whenever `core_rst_n` is low. It stays low after release until `init_done` is sampled high, and it goes high on that same edge.
- R6: `cfg_latch` is high for exactly one cycle per release, namely the first cycle in which `core_rst_n` is high.
- R7: While the sequencer is running, `periph_pins_o` follows `periph_pins_i` with one cycle of delay. During a warm reset and the initialization phase that follows it, `periph_pins_o` holds its last running value if `periph_en` was high in the last running cycle. Otherwise it is 0.
- R8: `last_reset_warm` is 1 after a valid warm reset taken from the running or initialization phase. It is 0 after power-on reset, including a power-on reset during which `warm_n` is held low.
- R9: An `init_done` pulse while `core_rst_n` is low has no effect. `rstat_n` stays low after release until a new pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_n | input | 1 | Warm reset request, active low, asynchronous |
| init_done | input | 1 | Device initialization finished (one-cycle pulse) |
| periph_en | input | 1 | Peripheral owning the retained pin group is enabled |
| periph_pins_i | input | PIN_W | Functional values for the retained pin group |
| core_rst_n | output | 1 | Reset for general internal logic, active low |
| pll2_rst_n | output | 1 | Reset for the second PLL, active low |
| test_rst_n | output | 1 | Reset for test and emulation logic, active low |
| cfg_latch | output | 1 | One-cycle strobe that captures configuration pins |
| rstat_n | output | 1 | Reset status, low while in reset or initializing |
| periph_pins_o | output | PIN_W | Retained pin group as driven to the pads |
| last_reset_warm | output | 1 | 1 if the last reset was a warm reset |

## Verification
The assertions assume that `por_n` is the only asynchronous reset and that it gates them off while low. They also assume that `init_done` is a clean synchronous pulse, and that `periph_pins_i` does not change in the cycle that a warm reset takes effect. The bench drives every input on the falling clock edge. It changes the peripheral pins only after `core_rst_n` is seen low, and it lowers `por_n` mid-cycle to exercise the asynchronous path without racing a sampling edge. Warm pulse widths are counted in whole clock periods, so the 23-cycle and 24-cycle cases fall on either side of the threshold.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [1:0] {
        PH_RESET = 2'd0,
        PH_INIT  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;
endpackage

// File: rtl/rstseq_sync.sv
// Multi-stage synchronizer with asynchronous preset/clear and synchronous release.
module rstseq_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/rstseq_warm_filter.sv
// Counts consecutive low samples of the synchronized warm request and
// signals once, on the sample that reaches the minimum width.
module rstseq_warm_filter #(
    parameter int MIN_LOW = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_n,
    output logic fire
);
    localparam int CW = $clog2(MIN_LOW + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (lvl_n)                     cnt_d = '0;
        else if (cnt_q < CW'(MIN_LOW)) cnt_d = cnt_q + 1'b1;
        fire = !lvl_n && (cnt_q == CW'(MIN_LOW - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
    parameter int WARM_MIN_CYCLES = 24,
    parameter int SYNC_STAGES     = 2,
    parameter int PIN_W           = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_n,
    input  logic             init_done,
    input  logic             periph_en,
    input  logic [PIN_W-1:0] periph_pins_i,
    output logic             core_rst_n,
    output logic             pll2_rst_n,
    output logic             test_rst_n,
    output logic             cfg_latch,
    output logic             rstat_n,
    output logic [PIN_W-1:0] periph_pins_o,
    output logic             last_reset_warm
);
    import rstseq_pkg::*;

    typedef struct packed {
        phase_e             phase;
        logic               cfg;
        logic               keep;
        logic [PIN_W-1:0]   pins;
        logic               last_warm;
    } seq_t;

    localparam seq_t SEQ_RST = '{phase: PH_RESET, cfg: 1'b0, keep: 1'b0,
                                 pins: '0, last_warm: 1'b0};

    logic por_s, warm_s, warm_fire;
    seq_t seq_d, seq_q;

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
        .clk    (clk),
        .arst_n (por_n),
        .d      (1'b1),
        .q      (por_s)
    );

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_warm_sync (
        .clk    (clk),
        .arst_n (por_n),
        .d      (warm_n),
        .q      (warm_s)
    );

    rstseq_warm_filter #(.MIN_LOW(WARM_MIN_CYCLES)) u_warm_filter (
        .clk   (clk),
        .rst_n (por_n),
        .lvl_n (warm_s),
        .fire  (warm_fire)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.cfg = 1'b0;
        unique case (seq_q.phase)
            PH_RESET: begin
                if (!seq_q.keep) seq_d.pins = '0;
                if (por_s && warm_s) begin
                    seq_d.phase = PH_INIT;
                    seq_d.cfg   = 1'b1;
                end
            end
            PH_INIT: begin
                if (warm_fire) begin
                    seq_d.phase     = PH_RESET;
                    seq_d.last_warm = 1'b1;
                end else if (init_done) begin
                    seq_d.phase = PH_RUN;
                end
            end
            PH_RUN: begin
                seq_d.pins = periph_pins_i;
                seq_d.keep = periph_en;
                if (warm_fire) begin
                    seq_d.phase     = PH_RESET;
                    seq_d.last_warm = 1'b1;
                end
            end
            default: seq_d.phase = PH_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign core_rst_n      = (seq_q.phase != PH_RESET);
    assign rstat_n         = (seq_q.phase == PH_RUN);
    assign pll2_rst_n      = por_s;
    assign test_rst_n      = por_s;
    assign cfg_latch       = seq_q.cfg;
    assign periph_pins_o   = seq_q.pins;
    assign last_reset_warm = seq_q.last_warm;
endmodule

// File: rtl/reset_sequencer_chk.sv
module reset_sequencer_chk #(
    parameter int PIN_W = 8
) (
    input logic             clk,
    input logic             por_n,
    input logic             init_done,
    input logic             core_rst_n,
    input logic             pll2_rst_n,
    input logic             test_rst_n,
    input logic             cfg_latch,
    input logic             rstat_n,
    input logic [PIN_W-1:0] periph_pins_o
);
    // R1: general logic never leaves reset while the PLL reset is held
    a_r1_core_after_pll2: assert property (@(posedge clk) disable iff (!por_n)
        !pll2_rst_n |-> !core_rst_n);

    // R2: the test reset is never released ahead of the general reset's source
    a_r2_test_gates_core: assert property (@(posedge clk) disable iff (!por_n)
        !test_rst_n |-> !core_rst_n);

    // R5: status is low whenever general reset is active
    a_r5_status_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        !core_rst_n |-> !rstat_n);

    // R5: status rises only right after init_done was seen
    a_r5_status_needs_init: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rstat_n) |-> $past(init_done));

    // R6: configuration strobe marks the release cycle
    a_r6_strobe_on_release: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst_n) |-> cfg_latch);

    // R6: configuration strobe lasts one cycle
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!por_n)
        cfg_latch |=> !cfg_latch);

    // R7: pin group is frozen once reset has settled
    a_r7_pins_frozen: assert property (@(posedge clk) disable iff (!por_n)
        (!core_rst_n && $past(!core_rst_n) && $past(!core_rst_n, 2))
        |-> $stable(periph_pins_o));
endmodule

bind reset_sequencer reset_sequencer_chk #(.PIN_W(PIN_W)) u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .init_done     (init_done),
    .core_rst_n    (core_rst_n),
    .pll2_rst_n    (pll2_rst_n),
    .test_rst_n    (test_rst_n),
    .cfg_latch     (cfg_latch),
    .rstat_n       (rstat_n),
    .periph_pins_o (periph_pins_o)
);

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PIN_W      = 8;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             warm_n = 1'b1;
    logic             init_done = 1'b0;
    logic             periph_en = 1'b0;
    logic [PIN_W-1:0] periph_pins_i = '0;
    logic             core_rst_n, pll2_rst_n, test_rst_n, cfg_latch, rstat_n;
    logic [PIN_W-1:0] periph_pins_o;
    logic             last_reset_warm;

    int  errors = 0;
    int  checks = 0;
    bit  saw_core_low = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_sequencer #(.WARM_MIN_CYCLES(24), .SYNC_STAGES(2), .PIN_W(PIN_W)) u_reset_sequencer (
        .clk             (clk),
        .por_n           (por_n),
        .warm_n          (warm_n),
        .init_done       (init_done),
        .periph_en       (periph_en),
        .periph_pins_i   (periph_pins_i),
        .core_rst_n      (core_rst_n),
        .pll2_rst_n      (pll2_rst_n),
        .test_rst_n      (test_rst_n),
        .cfg_latch       (cfg_latch),
        .rstat_n         (rstat_n),
        .periph_pins_o   (periph_pins_o),
        .last_reset_warm (last_reset_warm)
    );

    always @(negedge clk) if (!core_rst_n) saw_core_low = 1'b1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Release power-on reset with warm_n high; checks R2, R1, R6 timing.
    task automatic release_por();
        @(negedge clk) por_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(pll2_rst_n == 1'b1, "R2 pll2 released after 2 edges", pll2_rst_n, 1);
        chk(test_rst_n == 1'b1, "R2 test released after 2 edges", test_rst_n, 1);
        chk(core_rst_n == 1'b0, "R1 core still held at edge 2", core_rst_n, 0);
        @(posedge clk); #1;
        chk(core_rst_n == 1'b1, "R1 core released at edge 3", core_rst_n, 1);
        chk(cfg_latch == 1'b1, "R6 strobe on release", cfg_latch, 1);
        @(posedge clk); #1;
        chk(cfg_latch == 1'b0, "R6 strobe one cycle", cfg_latch, 0);
        chk(rstat_n == 1'b0, "R5 status low while initializing", rstat_n, 0);
    endtask

    task automatic finish_init();
        @(negedge clk) init_done = 1'b1;
        @(posedge clk); #1;
        chk(rstat_n == 1'b1, "R5 status high after init_done", rstat_n, 1);
        @(negedge clk) init_done = 1'b0;
    endtask

    task automatic warm_pulse(input int cycles);
        @(negedge clk) warm_n = 1'b0;
        repeat (cycles) @(negedge clk);
        warm_n = 1'b1;
    endtask

    task automatic t_power_on();
        repeat (5) @(negedge clk);
        chk(core_rst_n == 1'b0, "R4 core in reset", core_rst_n, 0);
        chk(pll2_rst_n == 1'b0, "R4 pll2 in reset", pll2_rst_n, 0);
        chk(test_rst_n == 1'b0, "R4 test in reset", test_rst_n, 0);
        chk(rstat_n == 1'b0, "R4 status low", rstat_n, 0);
        chk(cfg_latch == 1'b0, "R4 strobe low", cfg_latch, 0);
        chk(periph_pins_o == '0, "R4 pins zero", int'(periph_pins_o), 0);
        release_por();
        repeat (3) @(negedge clk);
        chk(rstat_n == 1'b0, "R5 status waits for init_done", rstat_n, 0);
        finish_init();
        chk(last_reset_warm == 1'b0, "R8 power-on cause", last_reset_warm, 0);
    endtask

    task automatic t_short_warm();
        saw_core_low = 1'b0;
        warm_pulse(23);
        repeat (10) @(negedge clk);
        chk(saw_core_low == 1'b0, "R3 23-cycle pulse ignored", saw_core_low, 0);
        chk(rstat_n == 1'b1, "R3 status unaffected", rstat_n, 1);
    endtask

    task automatic t_min_warm();
        saw_core_low = 1'b0;
        warm_pulse(24);
        repeat (10) @(negedge clk);
        chk(saw_core_low == 1'b1, "R3 24-cycle pulse accepted", saw_core_low, 1);
        chk(rstat_n == 1'b0, "R5 status low after warm reset", rstat_n, 0);
        chk(last_reset_warm == 1'b1, "R8 warm cause", last_reset_warm, 1);
        finish_init();
    endtask

    task automatic t_retain();
        @(negedge clk) begin periph_en = 1'b1; periph_pins_i = 8'hA5; end
        repeat (3) @(negedge clk);
        chk(periph_pins_o == 8'hA5, "R7 pins follow while running", int'(periph_pins_o), 'hA5);
        @(negedge clk) warm_n = 1'b0;
        repeat (30) @(negedge clk);
        chk(core_rst_n == 1'b0, "R3 held warm resets core", core_rst_n, 0);
        chk(pll2_rst_n == 1'b1, "R2 pll2 untouched by warm", pll2_rst_n, 1);
        chk(test_rst_n == 1'b1, "R2 test untouched by warm", test_rst_n, 1);
        periph_pins_i = 8'h3C;
        repeat (3) @(negedge clk);
        chk(periph_pins_o == 8'hA5, "R7 pins retained in warm reset", int'(periph_pins_o), 'hA5);
        warm_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 chk(core_rst_n == 1'b0, "R1 core held 2 edges after warm", core_rst_n, 0);
        @(posedge clk); #1;
        chk(core_rst_n == 1'b1, "R1 core released at edge 3", core_rst_n, 1);
        chk(cfg_latch == 1'b1, "R6 strobe on warm release", cfg_latch, 1);
        chk(periph_pins_o == 8'hA5, "R7 pins retained in init", int'(periph_pins_o), 'hA5);
        finish_init();
        @(negedge clk);
        chk(periph_pins_o == 8'h3C, "R7 pins follow after run", int'(periph_pins_o), 'h3C);
    endtask

    task automatic t_no_retain();
        @(negedge clk) begin periph_en = 1'b0; periph_pins_i = 8'h5A; end
        repeat (3) @(negedge clk);
        chk(periph_pins_o == 8'h5A, "R7 pins follow while running", int'(periph_pins_o), 'h5A);
        warm_pulse(30);
        chk(periph_pins_o == '0, "R7 disabled pins reset", int'(periph_pins_o), 0);
        repeat (5) @(negedge clk);
        finish_init();
    endtask

    task automatic t_init_ignored();
        @(negedge clk) warm_n = 1'b0;
        repeat (30) @(negedge clk);
        init_done = 1'b1;
        @(negedge clk) init_done = 1'b0;
        warm_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(core_rst_n == 1'b1, "R9 core released", core_rst_n, 1);
        chk(rstat_n == 1'b0, "R9 early init_done ignored", rstat_n, 0);
        finish_init();
    endtask

    task automatic t_warm_over_por();
        #2 por_n = 1'b0;
        @(negedge clk) warm_n = 1'b0;
        repeat (4) @(negedge clk);
        por_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(pll2_rst_n == 1'b1, "R2 pll2 released despite warm low", pll2_rst_n, 1);
        chk(test_rst_n == 1'b1, "R2 test released despite warm low", test_rst_n, 1);
        chk(core_rst_n == 1'b0, "R1 core held by warm low", core_rst_n, 0);
        warm_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 chk(core_rst_n == 1'b0, "R1 core held 2 edges", core_rst_n, 0);
        @(posedge clk); #1;
        chk(core_rst_n == 1'b1, "R1 core released at edge 3", core_rst_n, 1);
        chk(cfg_latch == 1'b1, "R6 strobe on later release", cfg_latch, 1);
        chk(last_reset_warm == 1'b0, "R8 still power-on cause", last_reset_warm, 0);
        finish_init();
    endtask

    task automatic t_async_por();
        @(negedge clk);
        #2 por_n = 1'b0;
        #1;
        chk(core_rst_n == 1'b0, "R4 async core reset", core_rst_n, 0);
        chk(pll2_rst_n == 1'b0, "R4 async pll2 reset", pll2_rst_n, 0);
        chk(test_rst_n == 1'b0, "R4 async test reset", test_rst_n, 0);
        chk(rstat_n == 1'b0, "R4 async status", rstat_n, 0);
        chk(last_reset_warm == 1'b0, "R8 cleared by power-on", last_reset_warm, 0);
        chk(periph_pins_o == '0, "R4 pins cleared", int'(periph_pins_o), 0);
        repeat (3) @(negedge clk);
        release_por();
    endtask

    initial begin
        t_power_on();
        t_short_warm();
        t_min_warm();
        t_retain();
        t_no_retain();
        t_init_ignored();
        t_warm_over_por();
        t_min_warm();
        t_async_por();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule